// File: doc/BRIEF.md
# Multi-Cycle Unsigned Multiplier with Carry/Overflow Flags

This block multiplies two unsigned integers one multiplier bit per clock using shift-and-add. The operation size is chosen per request: 8, 16 or 32 bits. One operand is the low part of an accumulator value presented on `acc_in`. The other comes from `src_in`. The double-width product is written back in register-pair form. The low half goes into the accumulator result, and for the two wider sizes the high half goes into a companion data result.

A request is made with a one-cycle `start` pulse while the block is idle. At that edge the block captures the operands, the size and the current accumulator and data values. It then runs one step per cycle and raises `done` for one cycle when the product is ready. The carry and overflow flags both report whether the upper half of the product is nonzero.

The sign, zero, auxiliary-carry and parity flags have no defined value after this operation, so the block has no outputs for them. Every bit of `acc_out` and `dat_out` outside the written field keeps the value captured at start.

Top module: `umul_flagged`

## Requirements
- R1: Size code 2'b00 (8-bit): acc_out[15:0] becomes acc_in[7:0]*src_in[7:0]. acc_out bits 16 and above and all of dat_out take the acc_in/dat_in values captured at start.
- R2: Size code 2'b01 (16-bit): acc_out[15:0] gets the low 16 bits of acc_in[15:0]*src_in[15:0] and dat_out[15:0] gets the high 16 bits. Bits 16 and above of both keep their captured values.
- R3: Size code 2'b10 (32-bit): acc_out[31:0] gets the low 32 bits of acc_in[31:0]*src_in[31:0] and dat_out[31:0] gets the high 32 bits.
- R4: cf and of are both 1 when the upper half of the product (bits 15:8, 31:16 or 63:32 by size) is nonzero, and both 0 otherwise.
- R5: busy rises at the edge that accepts start. done is a one-cycle pulse, high during the cycle after the edge that lies operand-width edges after acceptance, and busy is low in that same cycle. acc_out, dat_out, cf and of change only at that completion edge.
- R6: A start while busy is ignored. Changes on acc_in, dat_in, src_in and size during an operation do not affect its result.
- R7: A start with the reserved size code 2'b11 is ignored: busy stays low and all outputs keep their values.
- R8: During reset busy, done, cf, of, acc_out and dat_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| size | input | 2 | Operand size: 00=8, 01=16, 10=32, 11 reserved |
| src_in | input | 32 | Source operand (low bits used) |
| acc_in | input | DW | Accumulator value; implied operand and write-back base |
| dat_in | input | DW | Data register value; write-back base for high half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | DW | Accumulator result |
| dat_out | output | DW | Data register result |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |

## Verification
Once start is accepted, busy is due in the following cycle. done and all result fields are due exactly 8, 16 or 32 edges after the accepting edge, depending on size, and they must hold steady in every other cycle. The bench keeps a behavioural model that counts the same edges and compares every output one nanosecond after each rising edge. It therefore catches a result that is one cycle early, one cycle late or changes outside completion. Directed sequences also count the falling edges from the request to done and compare the count with the width plus one.

// File: rtl/umul_pkg.sv
package umul_pkg;
   typedef enum logic [1:0] {
      SZ_B8  = 2'b00,
      SZ_B16 = 2'b01,
      SZ_B32 = 2'b10,
      SZ_RSV = 2'b11
   } umul_size_e;

   localparam int MAX_OPW = 32;
   localparam int CNT_W   = $clog2(MAX_OPW);

   function automatic logic [CNT_W-1:0] steps_m1(umul_size_e s);
      case (s)
         SZ_B8:   steps_m1 = CNT_W'(8 - 1);
         SZ_B16:  steps_m1 = CNT_W'(16 - 1);
         default: steps_m1 = CNT_W'(32 - 1);
      endcase
   endfunction

   function automatic logic [MAX_OPW-1:0] op_mask(umul_size_e s);
      case (s)
         SZ_B8:   op_mask = MAX_OPW'(32'h0000_00FF);
         SZ_B16:  op_mask = MAX_OPW'(32'h0000_FFFF);
         default: op_mask = {MAX_OPW{1'b1}};
      endcase
   endfunction
endpackage

// File: rtl/umul_ctrl.sv
module umul_ctrl
   import umul_pkg::*;
#(
   parameter int CW = CNT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          size_ok,
   input  logic [CW-1:0] cnt_init,
   output logic          busy,
   output logic          load,
   output logic          finish,
   output logic          done
);
   logic [CW-1:0] cnt;

   assign load   = start & size_ok & ~busy;
   assign finish = busy & (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= finish;
         if (load) begin
            busy <= 1'b1;
            cnt  <= cnt_init;
         end else if (finish) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/umul_shiftadd.sv
module umul_shiftadd #(
   parameter int OPW = 32,
   localparam int PW = 2 * OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [OPW-1:0] a_in,
   input  logic [OPW-1:0] b_in,
   output logic [PW-1:0]  prod_nxt
);
   logic [PW-1:0]  mcand;
   logic [OPW-1:0] mplier;
   logic [PW-1:0]  prod;

   assign prod_nxt = prod + (mplier[0] ? mcand : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand  <= '0;
         mplier <= '0;
         prod   <= '0;
      end else if (load) begin
         mcand  <= {{OPW{1'b0}}, a_in};
         mplier <= b_in;
         prod   <= '0;
      end else if (step) begin
         prod   <= prod_nxt;
         mcand  <= mcand << 1;
         mplier <= mplier >> 1;
      end
   end

   a_r3_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prod == '0));
endmodule

// File: rtl/umul_merge.sv
module umul_merge
   import umul_pkg::*;
#(
   parameter int DW  = 32,
   parameter int OPW = MAX_OPW
) (
   input  umul_size_e       sz,
   input  logic [2*OPW-1:0] prod,
   input  logic [DW-1:0]    acc_base,
   input  logic [DW-1:0]    dat_base,
   output logic [DW-1:0]    acc_new,
   output logic [DW-1:0]    dat_new,
   output logic             hi_nz
);
   localparam int NSZ = 3;
   localparam int WID [NSZ] = '{8, 16, 32};

   logic [NSZ-1:0] hi_vec;

   for (genvar g = 0; g < NSZ; g++) begin : g_hi
      assign hi_vec[g] = |prod[2*WID[g]-1 : WID[g]];
   end

   always_comb begin
      acc_new = acc_base;
      dat_new = dat_base;
      hi_nz   = 1'b0;
      case (sz)
         SZ_B8: begin
            acc_new[15:0] = prod[15:0];
            hi_nz         = hi_vec[0];
         end
         SZ_B16: begin
            acc_new[15:0] = prod[15:0];
            dat_new[15:0] = prod[31:16];
            hi_nz         = hi_vec[1];
         end
         default: begin
            acc_new[31:0] = prod[31:0];
            dat_new[31:0] = prod[63:32];
            hi_nz         = hi_vec[2];
         end
      endcase
   end
endmodule

// File: rtl/umul_flagged.sv
module umul_flagged
   import umul_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    size,
   input  logic [31:0]   src_in,
   input  logic [DW-1:0] acc_in,
   input  logic [DW-1:0] dat_in,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] acc_out,
   output logic [DW-1:0] dat_out,
   output logic          cf,
   output logic          of
);
   localparam int OPW = MAX_OPW;
   localparam int PW  = 2 * OPW;

   if (DW < OPW) begin : g_bad_dw
      $error("umul_flagged: DW must be at least %0d", OPW);
   end

   umul_size_e      sz_in, sz_q;
   logic            load, finish, size_ok;
   logic [OPW-1:0]  a_op, b_op, msk;
   logic [PW-1:0]   prod_nxt;
   logic [DW-1:0]   acc_q, dat_q, acc_new, dat_new;
   logic            hi_nz;

   assign sz_in   = umul_size_e'(size);
   assign size_ok = (sz_in != SZ_RSV);
   assign msk     = op_mask(sz_in);
   assign a_op    = acc_in[OPW-1:0] & msk;
   assign b_op    = src_in & msk;

   umul_ctrl #(.CW(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .size_ok(size_ok),
      .cnt_init(steps_m1(sz_in)), .busy(busy), .load(load),
      .finish(finish), .done(done)
   );

   umul_shiftadd #(.OPW(OPW)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
      .a_in(a_op), .b_in(b_op), .prod_nxt(prod_nxt)
   );

   umul_merge #(.DW(DW), .OPW(OPW)) u_merge (
      .sz(sz_q), .prod(prod_nxt), .acc_base(acc_q), .dat_base(dat_q),
      .acc_new(acc_new), .dat_new(dat_new), .hi_nz(hi_nz)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sz_q    <= SZ_B8;
         acc_q   <= '0;
         dat_q   <= '0;
         acc_out <= '0;
         dat_out <= '0;
         cf      <= 1'b0;
         of      <= 1'b0;
      end else begin
         if (load) begin
            sz_q  <= sz_in;
            acc_q <= acc_in;
            dat_q <= dat_in;
         end
         if (finish) begin
            acc_out <= acc_new;
            dat_out <= dat_new;
            cf      <= hi_nz;
            of      <= hi_nz;
         end
      end
   end

   a_r1_flag_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sz_q == SZ_B8) |-> (cf == (acc_out[15:8] != '0)));
   a_r2_flag_word: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sz_q == SZ_B16) |-> (cf == (dat_out[15:0] != '0)));
   a_r4_flag_dword: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sz_q == SZ_B32) |-> (of == (dat_out[31:0] != '0)));
   a_r5_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(acc_out) && $stable(dat_out) && $stable(cf)));
   a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && size == 2'b11) |=> !busy);
endmodule

// File: tb/tb_umul_flagged.sv
`timescale 1ns/1ps
module tb_umul_flagged;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    size = 2'b00;
   logic [31:0]   src_in = '0;
   logic [DW-1:0] acc_in = '0, dat_in = '0;
   logic          busy, done, cf, of;
   logic [DW-1:0] acc_out, dat_out;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   umul_flagged #(.DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .size(size), .src_in(src_in),
      .acc_in(acc_in), .dat_in(dat_in), .busy(busy), .done(done),
      .acc_out(acc_out), .dat_out(dat_out), .cf(cf), .of(of)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit            m_busy, m_done, m_cf;
   int            m_left;
   logic [1:0]    m_sz;
   logic [31:0]   m_a, m_b;
   logic [DW-1:0] m_acc, m_dat, m_cacc, m_cdat;

   function automatic int width_of(logic [1:0] s);
      return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
   endfunction

   function automatic logic [31:0] mask_of(logic [1:0] s);
      return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   always @(posedge clk) begin
      logic [63:0] p;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cf = 0; m_left = 0;
         m_acc = '0; m_dat = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (m_left == 1) begin
               m_busy = 0;
               m_done = 1;
               p = {32'b0, m_a} * {32'b0, m_b};
               m_acc = m_cacc;
               m_dat = m_cdat;
               case (m_sz)
                  2'b00: begin m_acc[15:0] = p[15:0]; m_cf = |p[15:8]; end
                  2'b01: begin m_acc[15:0] = p[15:0]; m_dat[15:0] = p[31:16]; m_cf = |p[31:16]; end
                  default: begin m_acc[31:0] = p[31:0]; m_dat[31:0] = p[63:32]; m_cf = |p[63:32]; end
               endcase
            end else begin
               m_left--;
            end
         end else if (start && size != 2'b11) begin
            m_busy = 1;
            m_left = width_of(size);
            m_sz   = size;
            m_a    = acc_in[31:0] & mask_of(size);
            m_b    = src_in & mask_of(size);
            m_cacc = acc_in;
            m_cdat = dat_in;
         end
      end
      #1;
      if (!rst_n) begin
         chk("R8 reset busy", 64'(busy), 64'(0));
         chk("R8 reset done", 64'(done), 64'(0));
         chk("R8 reset acc", 64'(acc_out), 64'(0));
         chk("R8 reset dat", 64'(dat_out), 64'(0));
         chk("R8 reset flags", 64'({cf, of}), 64'(0));
      end else begin
         chk("R5 busy", 64'(busy), 64'(m_busy));
         chk("R5 done", 64'(done), 64'(m_done));
         chk(m_sz == 2'b00 ? "R1 acc" : m_sz == 2'b01 ? "R2 acc" : "R3 acc",
             64'(acc_out), 64'(m_acc));
         chk(m_sz == 2'b00 ? "R1 dat" : m_sz == 2'b01 ? "R2 dat" : "R3 dat",
             64'(dat_out), 64'(m_dat));
         chk("R4 cf", 64'(cf), 64'(m_cf));
         chk("R4 of", 64'(of), 64'(m_cf));
      end
   end

   // directed operation with latency count and direct result checks
   task automatic run_op(input logic [1:0] s, input logic [31:0] src,
                         input logic [DW-1:0] acc, input logic [DW-1:0] dat,
                         input logic [DW-1:0] exp_acc, input logic [DW-1:0] exp_dat,
                         input logic exp_flag, input string tag);
      int k;
      @(negedge clk);
      size = s; src_in = src; acc_in = acc; dat_in = dat; start = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
         if (k == 1) begin
            start = 1'b0;
            src_in = ~src; acc_in = ~acc; dat_in = ~dat;
         end
      end while (!done && k < 100);
      chk({"R5 latency ", tag}, 64'(k), 64'(width_of(s) + 1));
      chk({tag, " acc"}, 64'(acc_out), 64'(exp_acc));
      chk({tag, " dat"}, 64'(dat_out), 64'(exp_dat));
      chk({"R4 flag ", tag}, 64'({cf, of}), 64'({exp_flag, exp_flag}));
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 byte size
      run_op(2'b00, 32'h0000_0005, 32'hDEAD_BE03, 32'hCAFE_F00D,
             32'hDEAD_000F, 32'hCAFE_F00D, 1'b0, "R1 small");
      run_op(2'b00, 32'hFFFF_FFFF, 32'h1234_56FF, 32'h5555_AAAA,
             32'h1234_FE01, 32'h5555_AAAA, 1'b1, "R1 max");
      run_op(2'b00, 32'h0000_0010, 32'h0000_0010, 32'h0,
             32'h0000_0100, 32'h0, 1'b1, "R1 edge");
      // R2 word size
      run_op(2'b01, 32'h0000_0002, 32'hABCD_1234, 32'h9876_5432,
             32'hABCD_2468, 32'h9876_0000, 1'b0, "R2 small");
      run_op(2'b01, 32'h7777_FFFF, 32'h0101_FFFF, 32'hFFFF_FFFF,
             32'h0101_0001, 32'hFFFF_FFFE, 1'b1, "R2 max");
      // R3 dword size
      run_op(2'b10, 32'h0001_0000, 32'h0000_FFFF, 32'h1111_1111,
             32'hFFFF_0000, 32'h0000_0000, 1'b0, "R3 small");
      run_op(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,
             32'h0000_0001, 32'hFFFF_FFFE, 1'b1, "R3 max");
      run_op(2'b10, 32'h0, 32'h8765_4321, 32'h2222_2222,
             32'h0, 32'h0, 1'b0, "R3 zero");

      // R6: restart while busy is ignored
      @(negedge clk);
      size = 2'b01; src_in = 32'h3; acc_in = 32'h0000_0007; dat_in = 32'h0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      size = 2'b00; src_in = 32'hFF; acc_in = 32'hFF; dat_in = 32'hFFFF_FFFF; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R6 still busy", 64'(busy), 64'(1));
      begin
         int k = 0;
         while (!done && k < 100) begin @(negedge clk); k++; end
         chk("R6 restart gap", 64'(k), 64'(16 - 4));
      end
      chk("R6 acc", 64'(acc_out), 64'(32'h0000_0015));
      chk("R6 dat", 64'(dat_out), 64'(0));

      // R7: reserved size code ignored
      @(negedge clk);
      size = 2'b11; src_in = 32'hFFFF; acc_in = 32'hFFFF; dat_in = 32'h1234; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R7 busy low", 64'(busy), 64'(0));
      repeat (40) @(negedge clk);
      chk("R7 no done", 64'(done), 64'(0));
      chk("R7 acc held", 64'(acc_out), 64'(32'h0000_0015));
      chk("R7 flags held", 64'({cf, of}), 64'(0));

      // back-to-back starts immediately after completion
      run_op(2'b00, 32'h80, 32'h2, 32'h0, 32'h0000_0100, 32'h0, 1'b1, "R1 b2b");
      run_op(2'b01, 32'h100, 32'h100, 32'h0, 32'h0, 32'h1, 1'b1, "R2 b2b");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule